// File: doc/BRIEF.md
# Registered Bus Transceiver with Parity

The block sits between two local data words and a shared, active-low, bidirectional bus of `W` bits (four by default). In the outbound direction a select input picks one of the two local words, a rising clock edge captures it into a driver register, and the register's complement is presented on the bus. The driver appears on the bus only while the active-low bus enable is asserted. When the enable is released, the bus becomes an input.

In the inbound direction, the bus value is inverted and passed to a receiver stage with an active-low latch enable. While the enable is low, the stage is transparent. While it is high, the stage holds its value. The bus pin is split into a separate input, output and output-enable, so the pad ring can build the tri-state buffer.

A single parity output reports the XOR of the word that is active in the current direction:
- When driving, it is the selected local word, taken combinationally before any clock edge.
- When receiving, it is the bus word.

Top module: `bus_xcvr_par`

## Requirements
- R1: On each rising `clk` edge with `rst` low, the driver register loads `a_word` when `sel` is 0 and `b_word` when `sel` is 1.
- R2: `bus_out` is the bitwise complement of the driver register. For example, a loaded word 0001 gives `bus_out` 1110.
- R3: A rising edge with `rst` high clears the driver register to all zeros, so `bus_out` reads all ones. The same edge clears the receiver hold value to all zeros.
- R4: `bus_oe` is 1 exactly when `bus_oe_n` is 0. While `bus_oe_n` is 1, the block drives no bus value.
- R5: While `rx_le_n` is 0, `rx_word` equals the bitwise complement of `bus_in` in the same cycle, with no clock edge needed. For example, bus 0001 gives `rx_word` 1110.
- R6: While `rx_le_n` is 1, `rx_word` keeps the complement of the `bus_in` value sampled at the last rising `clk` edge at which `rx_le_n` was 0. Later changes on `bus_in` have no effect on `rx_word`. For example, after latching bus 1111, `rx_word` stays 0000 when the bus moves to 0000.
- R7: While `bus_oe_n` is 0, `parity` is the XOR of all bits of the currently selected word (`a_word` or `b_word`), combinationally. Examples: 0000→0, 0001→1, 0011→0, 0111→1, 1111→0.
- R8: While `bus_oe_n` is 1, `parity` is the XOR of all bits of `bus_in`.
- R9: Bit i of `a_word` and `b_word` maps to bit i of `bus_out`, and bit i of `bus_in` maps to bit i of `rx_word`, with no reordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Driver clock; the register loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Word select: 0 picks `a_word`, 1 picks `b_word` |
| a_word | input | W | First local data word |
| b_word | input | W | Second local data word |
| bus_oe_n | input | 1 | Active-low bus drive enable |
| rx_le_n | input | 1 | Active-low receiver latch enable (low means transparent) |
| bus_in | input | W | Value currently on the bus pins |
| bus_out | output | W | Value to drive onto the bus (active low) |
| bus_oe | output | 1 | Output enable for the bus pad buffers |
| rx_word | output | W | Receiver output, the inverted bus word |
| parity | output | 1 | XOR of the word active in the current direction |

## Verification
The checker watches the following on every cycle:
- the register update against the select and words of the previous edge;
- the reset value;
- the complement relation between enable and pad enable;
- receiver transparency;
- the stability of the receiver while it holds;
- the parity source switching with the bus direction.

The directed scenarios are needed for the rest. They show the specific parity examples, the walking-one bit mapping, and that a bus change after latching leaves the held value untouched. They also show that parity and receiver outputs respond within a cycle, before any clock edge.

// File: rtl/bus_xcvr_par.sv
module bus_xcvr_par #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  logic         bus_oe_n,
  input  logic         rx_le_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] rx_word,
  output logic         parity
);

  logic [W-1:0] pick;
  logic [W-1:0] drv_q;
  logic [W-1:0] rx_hold;
  logic [W-1:0] rx_live;

  assign pick    = sel ? b_word : a_word;
  assign rx_live = ~bus_in;

  always_ff @(posedge clk) begin
    if (rst) drv_q <= '0;
    else     drv_q <= pick;
  end

  // Flop-plus-bypass form of a transparent-low latch: the flop tracks the
  // bus while open, the mux bypasses it so the output follows immediately.
  always_ff @(posedge clk) begin
    if (rst)          rx_hold <= '0;
    else if (!rx_le_n) rx_hold <= rx_live;
  end

  assign bus_out = ~drv_q;
  assign bus_oe  = ~bus_oe_n;
  assign rx_word = rx_le_n ? rx_hold : rx_live;
  assign parity  = bus_oe_n ? ^bus_in : ^pick;

endmodule

module bus_xcvr_par_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         sel,
  input logic [W-1:0] a_word,
  input logic [W-1:0] b_word,
  input logic         bus_oe_n,
  input logic         rx_le_n,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [W-1:0] rx_word,
  input logic         parity
);

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bus_out == ~($past(sel) ? $past(b_word) : $past(a_word)));

  assert_reset_R3: assert property (@(posedge clk)
    rst |=> (bus_out == {W{1'b1}}));

  assert_oe_R4: assert property (@(posedge clk) disable iff (rst)
    bus_oe != bus_oe_n);

  assert_transparent_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_le_n |-> rx_word == ~bus_in);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_le_n && $past(rx_le_n) && !$past(rst)) |-> $stable(rx_word));

  assert_par_drive_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> parity == ^(sel ? b_word : a_word));

  assert_par_recv_R8: assert property (@(posedge clk) disable iff (rst)
    bus_oe_n |-> parity == ^bus_in);

endmodule

bind bus_xcvr_par bus_xcvr_par_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .a_word(a_word), .b_word(b_word),
  .bus_oe_n(bus_oe_n), .rx_le_n(rx_le_n), .bus_in(bus_in),
  .bus_out(bus_out), .bus_oe(bus_oe), .rx_word(rx_word), .parity(parity)
);

// File: tb/bus_xcvr_par_bench.sv
module bus_xcvr_par_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel = 1'b0;
  logic [W-1:0] a_word = '0;
  logic [W-1:0] b_word = '0;
  logic         bus_oe_n = 1'b0;
  logic         rx_le_n = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic [W-1:0] rx_word;
  logic         parity;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_xcvr_par #(.W(W)) u_bus_xcvr_par (
    .clk(clk), .rst(rst), .sel(sel), .a_word(a_word), .b_word(b_word),
    .bus_oe_n(bus_oe_n), .rx_le_n(rx_le_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rx_word(rx_word), .parity(parity)
  );

  function automatic logic odd(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) if (v[i]) c++;
    return (c % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edge_step;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst = 1'b1; bus_oe_n = 1'b0; a_word = 4'b1010;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 bus_out after reset", bus_out, 4'b1111);
    rx_le_n = 1'b1; bus_in = 4'b0110; #1;
    chk("R3 rx hold after reset", rx_word, 4'b0000);
    @(negedge clk); rst = 1'b0; rx_le_n = 1'b0;
  endtask

  task automatic t_drive(input logic s);
    logic [W-1:0] pats [5] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111};
    bus_oe_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sel = s;
      if (s) begin b_word = pats[k]; a_word = ~pats[k]; end
      else   begin a_word = pats[k]; b_word = ~pats[k]; end
      #1;
      chk("R7 parity of selected word before edge", {3'b0, parity}, {3'b0, odd(pats[k])});
      edge_step();
      chk(s ? "R1 load b_word" : "R1 load a_word", bus_out, ~pats[k]);
      chk("R2 bus_out complement", ~bus_out, pats[k]);
    end
  endtask

  task automatic t_oe;
    @(negedge clk); bus_oe_n = 1'b0; #1;
    chk("R4 oe asserted", {3'b0, bus_oe}, 4'b0001);
    bus_oe_n = 1'b1; #1;
    chk("R4 oe released", {3'b0, bus_oe}, 4'b0000);
  endtask

  task automatic t_recv;
    logic [W-1:0] pats [5] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111};
    @(negedge clk); bus_oe_n = 1'b1; rx_le_n = 1'b0; sel = 1'b0; a_word = 4'b0001;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bus_in = pats[k]; #1;
      chk("R5 transparent receive", rx_word, ~pats[k]);
      chk("R8 parity of bus", {3'b0, parity}, {3'b0, odd(pats[k])});
    end
    @(posedge clk); @(negedge clk);
    rx_le_n = 1'b1; #1;
    chk("R6 held after latch", rx_word, 4'b0000);
    bus_in = 4'b0000; #1;
    chk("R6 bus change ignored", rx_word, 4'b0000);
    edge_step();
    chk("R6 still held after edge", rx_word, 4'b0000);
    @(negedge clk); rx_le_n = 1'b0; #1;
    chk("R5 reopen follows bus", rx_word, 4'b1111);
  endtask

  task automatic t_bitmap;
    for (int i = 0; i < W; i++) begin
      @(negedge clk); bus_oe_n = 1'b0; sel = 1'b1;
      b_word = 4'b0001 << i; a_word = '0;
      edge_step();
      chk("R9 driver bit position", bus_out, ~(4'b0001 << i));
      @(negedge clk); bus_oe_n = 1'b1; rx_le_n = 1'b0; bus_in = 4'b0001 << i; #1;
      chk("R9 receiver bit position", rx_word, ~(4'b0001 << i));
    end
  endtask

  initial begin
    t_reset();
    t_drive(1'b0);
    t_drive(1'b1);
    t_oe();
    t_recv();
    t_bitmap();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule